// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block is a purely combinational two's-complement adder. It splits the operand width into equal groups of bits. Inside each group, every carry is formed directly from the per-bit generate and propagate terms and the group's carry-in, so no carry inside a group waits on another internal carry. The groups are then linked in a chain: the carry leaving one group is the carry entering the next, and the carry leaving the top group is the adder's carry-out.

Besides the sum and carry-out, the block raises a signed-overflow flag. The flag is the exclusive-or of the carry entering the most significant bit and the carry leaving it. It is meant for datapaths that want a short carry path inside each group at modest gate cost, without a second level of lookahead. The default build is 16 bits wide, made of four groups of 4 bits. The group size is a parameter and must divide the width.

Top module: `cla_adder`

## Requirements
- R1: `sumOut` equals the low DATA_W bits of opA + opB + carryIn, with all three taken as unsigned numbers.
- R2: `carryOut` equals bit DATA_W of the unsigned total opA + opB + carryIn.
- R3: `overflow` is 1 exactly when opA and opB, read as two's-complement numbers, plus carryIn (read as +1), give a result outside the signed DATA_W-bit range.
- R4: All ones plus 1 (carryIn = 0) gives sumOut = 0, carryOut = 1 and overflow = 0.
- R5: The most positive value (0 followed by ones) plus 1 gives the most negative value (1 followed by zeros), with carryOut = 0 and overflow = 1.
- R6: The most negative value plus all ones (minus one) gives the most positive value, with carryOut = 1 and overflow = 1.
- R7: A carry-in of 1 with opA = all ones and opB = 0 travels through every group: sumOut = 0, carryOut = 1, overflow = 0.
- R8: The carry leaving each group equals the carry of the unsigned sum of that group's operand slices plus the carry entering the group. At the ports, a carry that leaves the lowest group sets the lowest bit of the next group.
- R9: Results obey R1 to R3 for any group size that divides the width. This includes a non-default build with a 12-bit width and 3-bit groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| carryIn | input | 1 | Carry into the least significant bit |
| sumOut | output | DATA_W | Sum bits |
| carryOut | output | 1 | Carry out of the most significant bit |
| overflow | output | 1 | Signed overflow flag |

## Verification
The bench builds two copies of the block. One uses the defaults: 16 bits in four 4-bit groups. The other is 12 bits wide with four 3-bit groups, which exercises a group size that is not a power of two and a top group whose most significant bit sits at a different place. Both copies receive the same random and corner-case operands, truncated to their widths. Between them they reach carry chains that cross every group boundary and the overflow rule in two different top groups.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int MAX_GRP = 32;
  typedef logic [MAX_GRP-1:0] grpVec_t;

  // Carry into bit idx of a group, built only from gen, prop and the
  // group carry-in: every term is an AND chain, then one wide OR.
  function automatic logic flatCarry(grpVec_t gen, grpVec_t prop, logic cIn, int idx);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < idx; k++) begin
      term = gen[k];
      for (int m = k + 1; m < idx; m++) term = term & prop[m];
      acc = acc | term;
    end
    term = cIn;
    for (int m = 0; m < idx; m++) term = term & prop[m];
    return acc | term;
  endfunction
endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] bitsA,
  input  logic [GROUP_W-1:0] bitsB,
  output logic [GROUP_W-1:0] gen,
  output logic [GROUP_W-1:0] prop
);
  for (genvar i = 0; i < GROUP_W; i++) begin : g_bit
    assign gen[i]  = bitsA[i] & bitsB[i];
    assign prop[i] = bitsA[i] ^ bitsB[i];
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] gen,
  input  logic [GROUP_W-1:0] prop,
  input  logic               cIn,
  output logic [GROUP_W:0]   carries
);
  import cla_pkg::*;

  assign carries[0] = cIn;
  for (genvar j = 1; j <= GROUP_W; j++) begin : g_carry
    assign carries[j] = flatCarry(grpVec_t'(gen), grpVec_t'(prop), cIn, j);
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GROUP_W = 4,
  parameter bit IS_TOP  = 1'b0
) (
  input  logic [GROUP_W-1:0] grpA,
  input  logic [GROUP_W-1:0] grpB,
  input  logic               cIn,
  output logic [GROUP_W-1:0] grpSum,
  output logic               cOut,
  output logic               ovfOut
);
  logic [GROUP_W-1:0] gen;
  logic [GROUP_W-1:0] prop;
  logic [GROUP_W:0]   carries;

  cla_pg #(.GROUP_W(GROUP_W)) pgInst (
    .bitsA(grpA), .bitsB(grpB), .gen(gen), .prop(prop)
  );

  cla_lookahead #(.GROUP_W(GROUP_W)) laInst (
    .gen(gen), .prop(prop), .cIn(cIn), .carries(carries)
  );

  assign grpSum = prop ^ carries[GROUP_W-1:0];
  assign cOut   = carries[GROUP_W];

  if (IS_TOP) begin : g_ovf
    assign ovfOut = carries[GROUP_W-1] ^ carries[GROUP_W];
  end else begin : g_noOvf
    assign ovfOut = 1'b0;
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sumOut,
  output logic              carryOut,
  output logic              overflow
);
  localparam int NUM_GROUPS = DATA_W / GROUP_W;

  logic [NUM_GROUPS:0]   grpCarry;
  logic [NUM_GROUPS-1:0] grpOvf;

  assign grpCarry[0] = carryIn;

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
    cla_group #(
      .GROUP_W(GROUP_W),
      .IS_TOP (gi == NUM_GROUPS - 1)
    ) grpInst (
      .grpA  (opA[gi*GROUP_W +: GROUP_W]),
      .grpB  (opB[gi*GROUP_W +: GROUP_W]),
      .cIn   (grpCarry[gi]),
      .grpSum(sumOut[gi*GROUP_W +: GROUP_W]),
      .cOut  (grpCarry[gi+1]),
      .ovfOut(grpOvf[gi])
    );
  end

  assign carryOut = grpCarry[NUM_GROUPS];
  assign overflow = |grpOvf;
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 4
) (
  input logic [DATA_W-1:0]            opA,
  input logic [DATA_W-1:0]            opB,
  input logic                         carryIn,
  input logic [DATA_W-1:0]            sumOut,
  input logic                         carryOut,
  input logic                         overflow,
  input logic [DATA_W/GROUP_W:0]      grpCarry
);
  localparam int NUM_GROUPS = DATA_W / GROUP_W;

  logic [DATA_W:0] total;
  logic            signSame;
  logic            signFlip;

  assign total    = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
  assign signSame = opA[DATA_W-1] == opB[DATA_W-1];
  assign signFlip = sumOut[DATA_W-1] != opA[DATA_W-1];

  always_comb begin
    // R1
    sum_match_chk: assert (sumOut == total[DATA_W-1:0]);
    // R2
    carry_out_chk: assert (carryOut == total[DATA_W]);
    // R3
    no_overflow_chk: assert (overflow == (signSame && signFlip));
    // R7
    chain_through_chk: assert (!(carryIn && (&opA) && (opB == '0)) || (carryOut && sumOut == '0));
  end

  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grpChk
    logic [GROUP_W:0] sliceTotal;
    assign sliceTotal = {1'b0, opA[gi*GROUP_W +: GROUP_W]}
                      + {1'b0, opB[gi*GROUP_W +: GROUP_W]}
                      + {{GROUP_W{1'b0}}, grpCarry[gi]};
    always_comb begin
      // R8
      group_carry_chk: assert (grpCarry[gi+1] == sliceTotal[GROUP_W]);
    end
  end
endmodule

bind cla_adder cla_adder_chk #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) chkInst (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut),
  .carryOut(carryOut), .overflow(overflow), .grpCarry(grpCarry)
);

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W0 = 16;
  localparam int W1 = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W0-1:0] a0, b0, s0;
  logic [W1-1:0] a1, b1, s1;
  logic cin, co0, ov0, co1, ov1;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  cla_adder dut (
    .opA(a0), .opB(b0), .carryIn(cin),
    .sumOut(s0), .carryOut(co0), .overflow(ov0)
  );

  cla_adder #(.DATA_W(W1), .GROUP_W(3)) dutAlt (
    .opA(a1), .opB(b1), .carryIn(cin),
    .sumOut(s1), .carryOut(co1), .overflow(ov1)
  );

  task automatic check(string req, longint act, longint exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint toSigned(longint v, int w);
    return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
  endfunction

  task automatic checkWidth(string tag, int w, longint a, longint b, longint c,
                            longint s, longint co, longint ov);
    longint mask, tot, sres, hi, lo;
    mask = (longint'(1) << w) - 1;
    tot  = (a & mask) + (b & mask) + c;
    sres = toSigned(a & mask, w) + toSigned(b & mask, w) + c;
    hi   = (longint'(1) << (w - 1)) - 1;
    lo   = -(longint'(1) << (w - 1));
    check({tag, " R1 sum"}, s, tot & mask);
    check({tag, " R2 carry"}, co, (tot >> w) & 1);
    check({tag, " R3 overflow"}, ov, (sres > hi || sres < lo) ? 1 : 0);
  endtask

  task automatic applyVec(string tag, logic [W0-1:0] a, logic [W0-1:0] b, logic c);
    @(posedge clk);
    a0 = a; b0 = b; cin = c;
    a1 = a[W1-1:0]; b1 = b[W1-1:0];
    @(negedge clk);
    checkWidth(tag, W0, a, b, c, s0, co0, ov0);
    checkWidth({tag, " R9 alt"}, W1, a, b, c, s1, co1, ov1);
  endtask

  initial begin
    a0 = '0; b0 = '0; a1 = '0; b1 = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: zero operands give zero outputs (R1, R2, R3)
    check("R1 idle sum", s0, 0);
    check("R2 idle carry", co0, 0);
    check("R3 idle overflow", ov0, 0);

    // R4
    applyVec("R4", 16'hFFFF, 16'h0001, 1'b0);
    check("R4 sum", s0, 0); check("R4 carry", co0, 1); check("R4 ovf", ov0, 0);
    // R5
    applyVec("R5", 16'h7FFF, 16'h0001, 1'b0);
    check("R5 sum", s0, 16'h8000); check("R5 carry", co0, 0); check("R5 ovf", ov0, 1);
    // R6
    applyVec("R6", 16'h8000, 16'hFFFF, 1'b0);
    check("R6 sum", s0, 16'h7FFF); check("R6 carry", co0, 1); check("R6 ovf", ov0, 1);
    // R7
    applyVec("R7", 16'hFFFF, 16'h0000, 1'b1);
    check("R7 sum", s0, 0); check("R7 carry", co0, 1); check("R7 ovf", ov0, 0);
    // R8: carry out of lowest group sets bit 4
    applyVec("R8", 16'h000F, 16'h0001, 1'b0);
    check("R8 boundary sum", s0, 16'h0010);
    applyVec("R8", 16'h0F0F, 16'h0101, 1'b0);
    check("R8 two boundaries", s0, 16'h1010);
    applyVec("R3 neg", 16'h8000, 16'h8000, 1'b0);
    check("R3 neg ovf", ov0, 1);

    for (int i = 0; i < 3000; i++) begin
      applyVec("rand", 16'($urandom), 16'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule